// File: doc/BRIEF.md
# HDLC Receive Deframer with In-Band Escaping

This block sits behind a bit-clock recovery and NRZI decoder. It takes one decoded bit per accepted strobe and rebuilds the frame bytes. It watches an eight-bit history of the most recent bits to find frame delimiters (0x7E) and aborts (seven ones in a row). Inside a frame it drops the zero that a transmitter stuffs after five consecutive ones. It then assembles the remaining data bits into bytes, least significant bit first.

Every delimiter and every data byte is written into an internal byte FIFO, which a consumer drains through a valid/ready port. Frame boundaries stay in-band: each delimiter appears in the stream as 0x7E. A data byte whose value equals one of the control codes (0x7E, 0x7F or 0x1B) is preceded in the stream by the escape byte 0x1B, so the consumer can tell it from a real delimiter. The FIFO accepts one write per cycle. An escaped byte therefore needs two consecutive write cycles, and the block withholds its bit-ready signal for one cycle between them.

When a write finds the FIFO full, the byte is lost, the block returns to hunting for a delimiter, and a sticky overrun bit is set. The overrun bit stays set until the clear input is pulsed.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the block is hunting, the FIFO is empty (out_valid low), overrun is low and bit_ready is high.
- R2: When the bit history (newest bit in the LSB) equals 0x7E, the byte 0x7E is written to the FIFO and the block enters the in-frame state. This is the arrival order 0,1,1,1,1,1,1,0. The byte is visible on the output port in the cycle after the edge that accepted the last bit.
- R3: While hunting, bits that do not complete a 0x7E history produce no output.
- R4: In frame, data bits are gathered least significant bit first. The first data bit after a delimiter becomes bit 0, and the byte is written on the eighth data bit.
- R5: In frame, a bit whose arrival makes the low six history bits 111110 is a stuffed zero and is discarded.
- R6: A history whose low seven bits are all ones returns the block to hunting. No further data bytes are produced until the next delimiter.
- R7: A completed data byte equal to 0x7E, 0x7F or 0x1B is written as 0x1B followed by the byte, in two consecutive cycles. bit_ready is low for exactly the one cycle in between.
- R8: A write that finds the FIFO full is dropped. It sets overrun and returns the block to hunting, so later data bits are ignored until a delimiter.
- R9: Overrun stays high until clr_ovr is pulsed. If it is set and cleared in the same cycle, the set wins.
- R10: The output port keeps out_data steady while out_valid is high and out_ready is low. Bytes leave in write order, and the FIFO holds DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A decoded bit is offered on bit_in |
| bit_in | input | 1 | Decoded data bit |
| bit_ready | output | 1 | Bit is accepted when bit_valid and bit_ready are both high |
| clr_ovr | input | 1 | Pulse to clear the overrun bit |
| out_valid | output | 1 | A byte is available on out_data |
| out_data | output | 8 | Byte at the head of the FIFO |
| out_ready | input | 1 | Consumer takes the head byte |
| overrun | output | 1 | Sticky lost-byte indication |

## Verification
Each accepted bit goes through a single register stage into the FIFO. A written byte therefore shows on out_valid/out_data, the escape stall shows on bit_ready, and the overrun bit rises, all in the cycle after the clock edge that accepted the completing bit. The bench drives every bit at a falling edge and holds it across exactly one rising edge. It then reads bit_ready, out_valid and overrun at the next falling edge, which is the first point where those results are due. Output bytes are checked only after a frame has been fed. Each byte is compared at a falling edge, and out_ready is raised for a single rising edge, so each pop removes exactly one byte.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BITCNT_W = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_CODE = 8'h7F;
    localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h1B;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } push_req_t;

    // A byte that collides with an in-band control code must be escaped.
    function automatic logic needs_escape(input logic [BYTE_W-1:0] b);
        return (b == FLAG_CODE) || (b == ABORT_CODE) || (b == ESC_CODE);
    endfunction

    // Seven ones in the newest history bits end any frame in progress.
    function automatic logic is_abort(input logic [BYTE_W-1:0] h);
        return &h[6:0];
    endfunction

    // Five ones followed by the newest zero: the zero was stuffed.
    function automatic logic is_stuffed(input logic [BYTE_W-1:0] h);
        return h[5:0] == 6'b111110;
    endfunction

endpackage

// File: rtl/hdlc_rx_sticky.sv
module hdlc_rx_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_ready
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    assign full     = (count == FULL_CNT);
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rd_ptr];
    assign do_wr    = wr_en && !full;
    assign do_rd    = rd_valid && rd_ready;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_rx_parser.sv
module hdlc_rx_parser
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_valid,
    input  logic      bit_in,
    output logic      bit_ready,
    input  logic      fifo_full,
    output push_req_t push,
    output logic      drop
);
    logic [BYTE_W-1:0]   hist, hist_n, hist_shift;
    rx_state_e           state, state_n;
    logic [BYTE_W-1:0]   acc, acc_n, acc_with_bit;
    logic [BITCNT_W-1:0] cnt, cnt_n;
    logic                pend_vld, pend_vld_n;
    logic [BYTE_W-1:0]   pend_data, pend_data_n;
    logic                take;

    assign bit_ready    = !pend_vld;
    assign take         = bit_valid && !pend_vld;
    assign hist_shift   = {hist[BYTE_W-2:0], bit_in};
    assign acc_with_bit = acc | {bit_in, {(BYTE_W-1){1'b0}}};

    always_comb begin
        hist_n      = hist;
        state_n     = state;
        acc_n       = acc;
        cnt_n       = cnt;
        pend_vld_n  = pend_vld;
        pend_data_n = pend_data;
        push        = '0;
        drop        = 1'b0;

        if (pend_vld) begin
            // second half of an escaped pair
            pend_vld_n = 1'b0;
            if (fifo_full) begin
                drop    = 1'b1;
                state_n = ST_HUNT;
            end else begin
                push = '{vld: 1'b1, data: pend_data};
            end
        end else if (take) begin
            hist_n = hist_shift;
            if (hist_shift == FLAG_CODE) begin
                acc_n = '0;
                cnt_n = '0;
                if (fifo_full) begin
                    drop    = 1'b1;
                    state_n = ST_HUNT;
                end else begin
                    push    = '{vld: 1'b1, data: FLAG_CODE};
                    state_n = ST_FRAME;
                end
            end else if (is_abort(hist_shift)) begin
                state_n = ST_HUNT;
            end else if (state == ST_FRAME && !is_stuffed(hist_shift)) begin
                if (cnt == BITCNT_W'(BYTE_W - 1)) begin
                    acc_n = '0;
                    cnt_n = '0;
                    if (fifo_full) begin
                        drop    = 1'b1;
                        state_n = ST_HUNT;
                    end else if (needs_escape(acc_with_bit)) begin
                        push        = '{vld: 1'b1, data: ESC_CODE};
                        pend_vld_n  = 1'b1;
                        pend_data_n = acc_with_bit;
                    end else begin
                        push = '{vld: 1'b1, data: acc_with_bit};
                    end
                end else begin
                    acc_n = acc_with_bit >> 1;
                    cnt_n = cnt + BITCNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= '0;
            state     <= ST_HUNT;
            acc       <= '0;
            cnt       <= '0;
            pend_vld  <= 1'b0;
            pend_data <= '0;
        end else begin
            hist      <= hist_n;
            state     <= state_n;
            acc       <= acc_n;
            cnt       <= cnt_n;
            pend_vld  <= pend_vld_n;
            pend_data <= pend_data_n;
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              bit_ready,
    input  logic              clr_ovr,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              overrun
);
    push_req_t         push;
    logic              push_vld;
    logic [BYTE_W-1:0] push_data;
    logic              fifo_full;
    logic              drop;

    assign push_vld  = push.vld;
    assign push_data = push.data;

    hdlc_rx_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .bit_ready (bit_ready),
        .fifo_full (fifo_full),
        .push      (push),
        .drop      (drop)
    );

    hdlc_rx_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (BYTE_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (push_vld),
        .wr_data  (push_data),
        .full     (fifo_full),
        .rd_valid (out_valid),
        .rd_data  (out_data),
        .rd_ready (out_ready)
    );

    hdlc_rx_sticky u_ovr (
        .clk   (clk),
        .rst   (rst),
        .set_i (drop),
        .clr_i (clr_ovr),
        .q_o   (overrun)
    );
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
    import hdlc_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_ready,
    input logic              clr_ovr,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_ready,
    input logic              overrun,
    input logic              push_vld,
    input logic [BYTE_W-1:0] push_data,
    input logic              fifo_full,
    input logic              drop
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !overrun && bit_ready));

    assert_stall_single_R7: assert property (@(posedge clk) disable iff (rst)
        !bit_ready |=> bit_ready);

    assert_escape_first_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(bit_ready) |-> $past(push_vld && push_data == ESC_CODE));

    assert_no_write_full_R8: assert property (@(posedge clk) disable iff (rst)
        push_vld |-> !fifo_full);

    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(drop && fifo_full));

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_ovr) |=> overrun);

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_ready (bit_ready),
    .clr_ovr   (clr_ovr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .overrun   (overrun),
    .push_vld  (push_vld),
    .push_data (push_data),
    .fifo_full (fifo_full),
    .drop      (drop)
);

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;
    localparam int unsigned DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_ready;
    logic       clr_ovr = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       overrun;

    int total = 0;
    int bad = 0;
    int ones_run = 0;
    logic last_rdy = 1'b1;

    always #2.5 clk = ~clk;

    hdlc_rx_deframer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .bit_ready(bit_ready), .clr_ovr(clr_ovr), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .overrun(overrun)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one bit across exactly one rising edge; bit_ready sampled afterwards
    task automatic send_bit(input logic b);
        @(negedge clk);
        while (!bit_ready) @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        last_rdy  = bit_ready;
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit(8'h7E >> i);
        ones_run = 0;
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_data(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                ones_run++;
                if (ones_run == 5) begin
                    send_bit(1'b0);
                    ones_run = 0;
                end
            end else begin
                ones_run = 0;
            end
        end
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        check(out_valid === 1'b1, req, out_valid, 1);
        check(out_data === exp, req, out_data, exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        check(out_valid === 1'b0, req, out_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid === 1'b0, "R1", out_valid, 0);
        check(overrun === 1'b0, "R1", overrun, 0);
        check(bit_ready === 1'b1, "R1", bit_ready, 1);
    endtask

    task automatic t_hunt();
        send_raw(8'h55);
        send_raw(8'hA3);
        send_raw(8'h3C);
        expect_empty("R3");
    endtask

    task automatic t_basic();
        send_flag();
        // flag byte due in the cycle after the edge that took its last bit (R2)
        check(out_valid === 1'b1, "R2", out_valid, 1);
        send_data(8'hA5);
        send_data(8'h3C);
        send_flag();
        pop_expect(8'h7E, "R2");
        pop_expect(8'hA5, "R4");
        pop_expect(8'h3C, "R4");
        pop_expect(8'h7E, "R2");
        expect_empty("R4");
    endtask

    task automatic t_stuff();
        send_flag();
        send_data(8'hFF);
        send_data(8'hF8);
        send_data(8'h3F);
        send_flag();
        pop_expect(8'h7E, "R5");
        pop_expect(8'hFF, "R5");
        pop_expect(8'hF8, "R5");
        pop_expect(8'h3F, "R5");
        pop_expect(8'h7E, "R5");
        expect_empty("R5");
    endtask

    task automatic t_escape();
        send_flag();
        send_data(8'h7E);
        check(last_rdy === 1'b0, "R7", last_rdy, 0);
        @(negedge clk);
        check(bit_ready === 1'b1, "R7", bit_ready, 1);
        send_data(8'h1B);
        send_data(8'h7F);
        send_flag();
        pop_expect(8'h7E, "R7");
        pop_expect(8'h1B, "R7");
        pop_expect(8'h7E, "R7");
        pop_expect(8'h1B, "R7");
        pop_expect(8'h1B, "R7");
        pop_expect(8'h1B, "R7");
        pop_expect(8'h7F, "R7");
        pop_expect(8'h7E, "R7");
        expect_empty("R7");
    endtask

    task automatic t_abort();
        send_flag();
        send_data(8'h12);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        send_raw(8'h00);
        send_raw(8'h5A);
        pop_expect(8'h7E, "R6");
        pop_expect(8'h12, "R6");
        expect_empty("R6");
    endtask

    task automatic t_overrun();
        logic [7:0] held;
        send_flag();
        for (int i = 1; i < DEPTH; i++) send_data(8'(i));
        check(overrun === 1'b0, "R8", overrun, 0);
        send_data(8'h08);
        check(overrun === 1'b1, "R8", overrun, 1);
        send_data(8'h09);
        repeat (5) @(negedge clk);
        check(overrun === 1'b1, "R9", overrun, 1);
        held = out_data;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b1 && out_data === held, "R10", out_data, held);
        pop_expect(8'h7E, "R10");
        for (int i = 1; i < DEPTH; i++) pop_expect(8'(i), "R10");
        expect_empty("R8");
        check(overrun === 1'b1, "R9", overrun, 1);
        @(negedge clk);
        clr_ovr = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0;
        check(overrun === 1'b0, "R9", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hunt();
        t_basic();
        t_stuff();
        t_escape();
        t_abort();
        t_overrun();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule